// File: doc/BRIEF.md
# Codec Register Access Arbiter with Posted Writes

This block sits between a host register port and a slow serial link engine that carries codec register writes. Software owners coordinate through a single ownership bit held in an access register at a fixed address (`SEM_ADDR`, default 0x34, bit 0). Reading that register is a test-and-set operation. The read returns the current state of the bit, and the bit is then left set. An owner that reads 0 holds the link. An owner that reads 1 must retry later.

Writes to any other address are codec register writes. They are acknowledged on the next cycle, before the link has moved any data. The write is held in a one-entry buffer and offered to the link engine on a valid/ready interface. Once the engine accepts the write, the block waits for the engine's completion pulse. That pulse frees the buffer and releases the ownership bit in hardware.

An owner that decides not to write gives the bit back by writing 0 to bit 0 of the access register. A codec write that arrives while a transfer is outstanding is acknowledged like any other write, but it is discarded and a sticky error flag is raised.

Top module: `codec_access_arb`

## Requirements
- R1: Every cycle with `host_rd` or `host_wr` high is answered by `host_ack` high in the following cycle. `host_ack` is low after any cycle with neither input high.
- R2: A read of `SEM_ADDR` while the ownership bit is 0 returns 0 in `host_rdata[0]` in the ack cycle, and it leaves the bit set to 1.
- R3: A read of `SEM_ADDR` while the ownership bit is 1 returns 1 in `host_rdata[0]` and leaves the bit at 1.
- R4: A write to `SEM_ADDR` with `host_wdata[0]`=0 clears the ownership bit. A write with `host_wdata[0]`=1 leaves it unchanged.
- R5: A codec write accepted into an empty buffer raises `link_valid` in the next cycle, with `link_addr`/`link_data` equal to the written address and data. The back-pressure rules are: `link_valid`, `link_addr` and `link_data` stay stable while `link_ready` is low, and the transfer is handed off in the cycle where both `link_valid` and `link_ready` are high.
- R6: A `link_done` pulse while a handed-off transfer is outstanding empties the buffer and clears the ownership bit. A `link_done` pulse at any other time has no effect.
- R7: A codec write arriving while the buffer is occupied (offered or outstanding, including the cycle of `link_done`) is acknowledged. It is then discarded, and `drop_err` becomes 1 and stays 1 until reset.
- R8: When a test-and-set read coincides with the hardware clear, the read returns 0 and the bit ends at 1.
- R9: After reset the ownership bit is 0, and `host_ack`, `host_rdata`, `link_valid` and `drop_err` are 0.
- R10: The ack-cycle `host_rdata` is 0 for reads of codec addresses, and bits above bit 0 are always 0. A read never starts a link transfer.
- R11: A cycle with both `host_rd` and `host_wr` high is handled as a read only and is acknowledged once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Register address |
| host_rd | input | 1 | Read request, one cycle |
| host_wr | input | 1 | Write request, one cycle |
| host_wdata | input | DATA_W | Write data |
| host_ack | output | 1 | Completion, cycle after request |
| host_rdata | output | DATA_W | Read data, valid with ack |
| link_valid | output | 1 | Posted write offered to link engine |
| link_ready | input | 1 | Link engine accepts the offer |
| link_addr | output | ADDR_W | Codec register address of offer |
| link_data | output | DATA_W | Codec register data of offer |
| link_done | input | 1 | Link write finished, one-cycle pulse |
| drop_err | output | 1 | Sticky: a codec write was discarded |

## Verification
The main function is driven first by a directed sequence that walks the ownership bit through acquire, failed acquire, a write of 1 (ignored), a release by software, and a release by hardware. This sequence tells the test-and-set path apart from the plain clear paths. A held-off `link_ready` separates back-pressure stability from hand-off. Collisions are aimed at the edges: a read during the `link_done` cycle, a codec write during the offer and during the outstanding phase, `link_done` with no transfer outstanding, and a simultaneous read and write. A long random phase then mixes every request type against random ready and done pulses, and a behavioural model compares all outputs on every clock.

// File: rtl/codec_arb_pkg.sv
package codec_arb_pkg;
  typedef enum logic [1:0] {
    PB_IDLE  = 2'd0,
    PB_OFFER = 2'd1,
    PB_WAIT  = 2'd2
  } pb_state_t;
endpackage

// File: rtl/codec_own_flag.sv
module codec_own_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tas_rd,
  input  logic sw_clr,
  input  logic hw_clr,
  output logic seen,
  output logic owned
);
  logic flag_q;

  // value presented to a test-and-set read: hardware clear wins for the view
  assign seen  = flag_q & ~hw_clr;
  assign owned = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag_q <= 1'b0;
    else if (tas_rd)         flag_q <= 1'b1;
    else if (hw_clr | sw_clr) flag_q <= 1'b0;
  end

  AST_TAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tas_rd |=> flag_q); // R2
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tas_rd && (hw_clr || sw_clr)) |=> !flag_q); // R6
endmodule

// File: rtl/codec_post_buf.sv
module codec_post_buf
  import codec_arb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              link_ready,
  input  logic              link_done,
  output logic              link_valid,
  output logic [ADDR_W-1:0] link_addr,
  output logic [DATA_W-1:0] link_data,
  output logic              busy,
  output logic              done_hit
);
  pb_state_t         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign link_valid = (st_q == PB_OFFER);
  assign link_addr  = addr_q;
  assign link_data  = data_q;
  assign busy       = (st_q != PB_IDLE);
  assign done_hit   = (st_q == PB_WAIT) & link_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PB_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        PB_IDLE: if (cap_en) begin
          st_q   <= PB_OFFER;
          addr_q <= cap_addr;
          data_q <= cap_data;
        end
        PB_OFFER: if (link_ready) st_q <= PB_WAIT;
        PB_WAIT:  if (link_done)  st_q <= PB_IDLE;
        default:  st_q <= PB_IDLE;
      endcase
    end
  end

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && !link_ready) |=> (link_valid && $stable(link_addr) && $stable(link_data))); // R5
  AST_NO_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_hit) |=> busy); // R7
endmodule

// File: rtl/codec_access_arb.sv
module codec_access_arb #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 16,
  parameter logic [7:0]  SEM_ADDR = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              link_valid,
  input  logic              link_ready,
  output logic [ADDR_W-1:0] link_addr,
  output logic [DATA_W-1:0] link_data,
  input  logic              link_done,
  output logic              drop_err
);
  localparam logic [ADDR_W-1:0] SEM_A = ADDR_W'(SEM_ADDR);

  logic is_sem, wr_only, tas_rd, sw_clr, codec_wr, cap_en, drop_now;
  logic busy, done_hit, seen, owned;
  logic ack_q, err_q;
  logic [DATA_W-1:0] rdata_q;

  assign is_sem   = (host_addr == SEM_A);
  assign wr_only  = host_wr & ~host_rd;
  assign tas_rd   = host_rd & is_sem;
  assign sw_clr   = wr_only & is_sem & ~host_wdata[0];
  assign codec_wr = wr_only & ~is_sem;
  assign cap_en   = codec_wr & ~busy;
  assign drop_now = codec_wr & busy;

  codec_own_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tas_rd(tas_rd), .sw_clr(sw_clr),
    .hw_clr(done_hit), .seen(seen), .owned(owned)
  );

  codec_post_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_addr(host_addr),
    .cap_data(host_wdata), .link_ready(link_ready), .link_done(link_done),
    .link_valid(link_valid), .link_addr(link_addr), .link_data(link_data),
    .busy(busy), .done_hit(done_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      ack_q   <= host_rd | host_wr;
      rdata_q <= tas_rd ? DATA_W'(seen) : '0;
      if (drop_now) err_q <= 1'b1;
    end
  end

  assign host_ack   = ack_q;
  assign host_rdata = rdata_q;
  assign drop_err   = err_q;

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd || host_wr) |=> host_ack); // R1
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd || host_wr) |=> !host_ack); // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |=> drop_err); // R7
  AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[DATA_W-1:1] == '0); // R10
  AST_OWNED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (tas_rd && owned && !done_hit) |=> host_rdata[0]); // R3
endmodule

// File: tb/codec_access_arb_tb_top.sv
module codec_access_arb_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] SEM = 8'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic host_ack, link_valid, drop_err;
  logic [DW-1:0] host_rdata, link_data;
  logic [AW-1:0] link_addr;
  logic link_ready = 1'b0, link_done = 1'b0;

  always #5 clk = ~clk;

  codec_access_arb dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .link_valid(link_valid), .link_ready(link_ready),
    .link_addr(link_addr), .link_data(link_data), .link_done(link_done),
    .drop_err(drop_err)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference: 0 empty, 1 offered, 2 handed off
  int m_flag = 0, m_stage = 0, m_err = 0, m_ack = 0, m_rdata = 0;
  int m_addr = 0, m_data = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_stage = 0; m_err = 0; m_ack = 0; m_rdata = 0;
      m_addr = 0; m_data = 0;
    end else begin
      bit rd, wr, sem, hwc, cw;
      int seen_v, nstage;
      rd  = host_rd; wr = host_wr && !host_rd; sem = (host_addr == SEM);
      hwc = (m_stage == 2) && link_done;
      seen_v  = (m_flag == 1 && !hwc) ? 1 : 0;
      m_ack   = (host_rd || host_wr) ? 1 : 0;
      m_rdata = (rd && sem) ? seen_v : 0;
      cw = wr && !sem;
      nstage = m_stage;
      if (m_stage == 1 && link_ready) nstage = 2;
      if (hwc) nstage = 0;
      if (cw && m_stage == 0) begin
        nstage = 1; m_addr = int'(host_addr); m_data = int'(host_wdata);
      end
      if (cw && m_stage != 0) m_err = 1;
      if (rd && sem) m_flag = 1;
      else if (hwc || (wr && sem && host_wdata[0] == 1'b0)) m_flag = 0;
      m_stage = nstage;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R1 host_ack", int'(host_ack), m_ack);
    chk("R2/R3/R10 host_rdata", int'(host_rdata), m_rdata);
    chk("R5 link_valid", int'(link_valid), (m_stage == 1) ? 1 : 0);
    if (m_stage == 1) begin
      chk("R5 link_addr", int'(link_addr), m_addr);
      chk("R5 link_data", int'(link_data), m_data);
    end
    chk("R7 drop_err", int'(drop_err), m_err);
  end

  task automatic cyc(input bit rd, input bit wr, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input bit rdy, input bit dn);
    @(negedge clk); #1;
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
    link_ready = rdy; link_done = dn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 16'h0, 0, 0);
  endtask

  // read the access register and check bit 0 in the ack cycle
  task automatic sem_read(input string tag, input int exp, input bit dn);
    cyc(1, 0, SEM, 16'h0, 0, dn);
    idle(1);
    chk(tag, int'(host_rdata[0]), exp);
  endtask

  bit finished = 0;

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 ack", int'(host_ack), 0);
        chk("R9 valid", int'(link_valid), 0);
        chk("R9 err", int'(drop_err), 0);
        sem_read("R9 flag clear after reset", 0, 0);
        sem_read("R3 second read sees owned", 1, 0);
        cyc(0, 1, SEM, 16'h0001, 0, 0);
        sem_read("R4 write 1 ignored", 1, 0);
        cyc(0, 1, SEM, 16'hFFFE, 0, 0);
        sem_read("R4 write 0 clears, R2 reacquire", 0, 0);
        // posted write with back-pressure
        cyc(0, 1, 8'h10, 16'hABCD, 0, 0);
        idle(1);
        chk("R1 posted ack", int'(host_ack), 1);
        chk("R5 offered", int'(link_valid), 1);
        idle(3);
        chk("R5 held addr", int'(link_addr), 16'h10);
        chk("R5 held data", int'(link_data), 16'hABCD);
        cyc(0, 1, 8'h12, 16'h1111, 0, 0);
        idle(1);
        chk("R7 drop during offer", int'(drop_err), 1);
        chk("R7 original kept", int'(link_data), 16'hABCD);
        cyc(0, 0, 8'h00, 16'h0, 1, 0);
        idle(2);
        chk("R5 handed off", int'(link_valid), 0);
        sem_read("R6 still owned while outstanding", 1, 0);
        cyc(0, 1, 8'h14, 16'h2222, 0, 0);
        sem_read("R8 read during hw clear", 0, 1);
        sem_read("R8 bit set after collision", 1, 0);
        cyc(0, 0, 8'h00, 16'h0, 0, 1);
        sem_read("R6 stray done ignored", 1, 0);
        cyc(0, 1, 8'h16, 16'h3333, 0, 0);
        idle(1);
        chk("R7 buffer free after done", int'(link_valid), 1);
        cyc(0, 0, 8'h00, 16'h0, 1, 0);
        cyc(0, 0, 8'h00, 16'h0, 0, 1);
        sem_read("R6 hw clear releases", 0, 0);
        cyc(1, 1, SEM, 16'h0000, 0, 0);
        idle(1);
        chk("R11 rd+wr as read", int'(host_rdata[0]), 1);
        sem_read("R11 no clear from rd+wr", 1, 0);
        cyc(1, 0, 8'h20, 16'h0, 0, 0);
        idle(1);
        chk("R10 codec read zero", int'(host_rdata), 0);
        chk("R10 no transfer", int'(link_valid), 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
          int r = int'($urandom % 8);
          logic [AW-1:0] a = ($urandom % 3 == 0) ? SEM : AW'($urandom % 64);
          cyc(r == 0 || r == 1, r == 2 || r == 3 || r == 1, a, DW'($urandom),
              ($urandom % 3) != 0, ($urandom % 4) == 0);
        end
        idle(2);
        finished = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          checks++; fails++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule